// File: doc/BRIEF.md
# DMA Demand Request Decoder

This block sits beside a DMA controller and turns a 64-bit request word, placed on the data bus by an external device, into the register contents of demand channel 0. A request addressed to channel 0 loads that channel's control, count and address registers. The control fields come from the size, direction and mode fields of the word. A request addressed to channel 1, 2 or 3 changes no register and produces a one-cycle channel-select pulse for the rest of the controller.

Every accepted request is answered with a one-cycle active-low acknowledge and a two-bit channel number. A malformed request raises a one-cycle error flag and is otherwise dropped. A small CPU port reads the three channel 0 registers. Writes through that port are either refused, or accepted and later overwritten by requests, depending on a static policy input.

Top module: `dtr_decoder`

## Requirements
- R1: `req_word` is sampled on the rising edge where `req_valid` is high. For an accepted request, `ack_n` is low on the second cycle after that edge for one cycle, and `chan_id` then shows word bits 60:59.
- R2: For a channel 0 request, word bits 63:61 (000 = 8-bit, 001 = 16-bit, 010 = 32-bit) are copied into control bits 2:0.
- R3: For a channel 0 request, word bits 55:48 load the count register and bits 31:0 load the address register. Bits 47:32 have no effect.
- R4: Mode is word bits 57:56. Control bit 4 is 1 for mode 01 and 0 for modes 10 and 11. Control bit 3 is 0 for mode 11 and 1 for modes 01 and 10.
- R5: Direction is word bit 58. Control bits 8:5 become 0010 when it is 0 and 0011 when it is 1.
- R6: The other control fields are fixed on every channel 0 load: bits 10:9 = 01, bits 12:11 = 01, and bits 13, 14 and 15 = 0.
- R7: A request with a nonzero channel field leaves all channel 0 registers unchanged. It pulses `chsel_pulse` for one cycle, in the same cycle as the acknowledge.
- R8: A request with mode 00, or with a size code of 011 or above, changes no register and gives no acknowledge. It raises `req_err` for one cycle, in the cycle where the acknowledge would have come.
- R9: With `cpu_wr_open` low, CPU writes have no effect on any channel 0 register.
- R10: With `cpu_wr_open` high, a CPU write takes effect on the next cycle, and a later channel 0 request overwrites the written value.
- R11: After reset, `ack_n` is 1, `req_err` and `chsel_pulse` are 0, `chan_id` is 0, and all three registers read 0.
- R12: CPU reads are combinational. `cpu_sel` 0 selects control (16 bits, zero-extended), 1 selects count (zero-extended), 2 selects address, and 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request word present on the bus |
| req_word | input | 64 | Request word from the data bus |
| cpu_wr_open | input | 1 | 1: CPU may write channel 0 registers |
| cpu_we | input | 1 | CPU write strobe |
| cpu_sel | input | 2 | CPU register select |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data |
| ack_n | output | 1 | Active-low acknowledge, one cycle |
| chan_id | output | 2 | Channel number of the last accepted request |
| chsel_pulse | output | 1 | One-cycle select for channels 1 to 3 |
| req_err | output | 1 | One-cycle malformed-request flag |

## Verification
A wrong staging register, for example a lost valid bit, shows at the ports as a missing or misplaced acknowledge or error two cycles after the request. A wrong decode shows in the same cycle as a wrong field in the control register on the CPU port. A write-policy fault shows as a register value that differs from the model on the first read after the write. A fault in channel steering shows as a channel 0 register changed by a request for channel 1 to 3, or as a missing select pulse, so every request is followed by a read of all three registers.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  localparam int REQ_W    = 64;
  localparam int SIZE_HI  = 63;
  localparam int SIZE_LO  = 61;
  localparam int CHAN_HI  = 60;
  localparam int CHAN_LO  = 59;
  localparam int DIR_BIT  = 58;
  localparam int MODE_HI  = 57;
  localparam int MODE_LO  = 56;
  localparam int CNT_HI   = 55;
  localparam int CNT_LO   = 48;
  localparam int GAP_HI   = 47;
  localparam int GAP_LO   = 32;
  localparam int CTRL_W   = 16;

  typedef struct packed {
    logic       irq_en;
    logic       addr_rl;
    logic       cnt_rl;
    logic [1:0] dst_step;
    logic [1:0] src_step;
    logic [3:0] res_sel;
    logic       dst_side;
    logic       xfer_mode;
    logic [2:0] xfer_size;
  } ch0_ctrl_t;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_ADDR  = 2'd2,
    SEL_NONE  = 2'd3
  } cpu_sel_e;
endpackage

// File: rtl/dtr_capture.sv
module dtr_capture #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  output logic         stg_valid,
  output logic [W-1:0] stg_word
);
  logic         valid_d;
  logic [W-1:0] word_d;

  always_comb begin
    valid_d = in_valid;
    word_d  = stg_word;
    if (in_valid) word_d = in_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_valid <= 1'b0;
      stg_word  <= '0;
    end else begin
      stg_valid <= valid_d;
      stg_word  <= word_d;
    end
  end
endmodule

// File: rtl/dtr_field_decode.sv
module dtr_field_decode
  import dtr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic [REQ_W-1:0]  word,
  output logic [1:0]        chan,
  output logic              well_formed,
  output ch0_ctrl_t         ctrl,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] addr
);
  logic [2:0] size_f;
  logic [1:0] mode_f;
  logic       dir_f;
  logic       unused_gap;

  assign size_f     = word[SIZE_HI:SIZE_LO];
  assign mode_f     = word[MODE_HI:MODE_LO];
  assign dir_f      = word[DIR_BIT];
  assign chan       = word[CHAN_HI:CHAN_LO];
  assign count      = word[CNT_LO+CNT_W-1:CNT_LO];
  assign addr       = word[ADDR_W-1:0];
  assign unused_gap = ^word[GAP_HI:GAP_LO];

  always_comb begin
    well_formed    = (size_f <= 3'd2) && (mode_f != 2'b00);
    ctrl           = '0;
    ctrl.xfer_size = size_f;
    ctrl.xfer_mode = (mode_f != 2'b11);
    ctrl.dst_side  = (mode_f == 2'b01);
    ctrl.res_sel   = dir_f ? 4'b0011 : 4'b0010;
    ctrl.src_step  = 2'b01;
    ctrl.dst_step  = 2'b01;
    ctrl.cnt_rl    = 1'b0;
    ctrl.addr_rl   = 1'b0;
    ctrl.irq_en    = 1'b0;
  end
endmodule

// File: rtl/dtr_ch0_regs.sv
module dtr_ch0_regs
  import dtr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  ch0_ctrl_t         ld_ctrl,
  input  logic [CNT_W-1:0]  ld_count,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              wr_open,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_sel,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output ch0_ctrl_t         ctrl_q,
  output logic [CNT_W-1:0]  count_q,
  output logic [ADDR_W-1:0] addr_q
);
  ch0_ctrl_t         ctrl_d;
  logic [CNT_W-1:0]  count_d;
  logic [ADDR_W-1:0] addr_d;
  logic              cpu_wr_ok;
  logic              ctrl_en, count_en, addr_en;

  assign cpu_wr_ok = cpu_we && wr_open;

  always_comb begin
    ctrl_d   = ctrl_q;
    count_d  = count_q;
    addr_d   = addr_q;
    ctrl_en  = 1'b0;
    count_en = 1'b0;
    addr_en  = 1'b0;
    if (ld) begin
      ctrl_d   = ld_ctrl;
      count_d  = ld_count;
      addr_d   = ld_addr;
      ctrl_en  = 1'b1;
      count_en = 1'b1;
      addr_en  = 1'b1;
    end else if (cpu_wr_ok) begin
      case (cpu_sel_e'(cpu_sel))
        SEL_CTRL: begin
          ctrl_d  = ch0_ctrl_t'(cpu_wdata[CTRL_W-1:0]);
          ctrl_en = 1'b1;
        end
        SEL_COUNT: begin
          count_d  = cpu_wdata[CNT_W-1:0];
          count_en = 1'b1;
        end
        SEL_ADDR: begin
          addr_d  = cpu_wdata[ADDR_W-1:0];
          addr_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      count_q <= '0;
      addr_q  <= '0;
    end else begin
      if (ctrl_en)  ctrl_q  <= ctrl_d;
      if (count_en) count_q <= count_d;
      if (addr_en)  addr_q  <= addr_d;
    end
  end

  always_comb begin
    case (cpu_sel_e'(cpu_sel))
      SEL_CTRL:  cpu_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      SEL_COUNT: cpu_rdata = {{(DATA_W-CNT_W){1'b0}}, count_q};
      SEL_ADDR:  cpu_rdata = {{(DATA_W-ADDR_W){1'b0}}, addr_q};
      default:   cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dtr_decoder.sv
module dtr_decoder
  import dtr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [63:0]       req_word,
  input  logic              cpu_wr_open,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_sel,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              ack_n,
  output logic [1:0]        chan_id,
  output logic              chsel_pulse,
  output logic              req_err
);
  logic              stg_valid;
  logic [REQ_W-1:0]  stg_word;
  logic [1:0]        dec_chan;
  logic              dec_ok;
  ch0_ctrl_t         dec_ctrl;
  logic [CNT_W-1:0]  dec_count;
  logic [ADDR_W-1:0] dec_addr;
  logic              ch0_ld;
  ch0_ctrl_t         ch0_ctrl;
  logic [CNT_W-1:0]  ch0_count;
  logic [ADDR_W-1:0] ch0_addr;

  logic       ack_n_d, sel_d, err_d, id_en;
  logic [1:0] id_d;

  dtr_capture #(.W(REQ_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_word(req_word),
    .stg_valid(stg_valid), .stg_word(stg_word)
  );

  dtr_field_decode #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dec (
    .word(stg_word), .chan(dec_chan), .well_formed(dec_ok),
    .ctrl(dec_ctrl), .count(dec_count), .addr(dec_addr)
  );

  assign ch0_ld = stg_valid && dec_ok && (dec_chan == 2'b00);

  dtr_ch0_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld(ch0_ld), .ld_ctrl(dec_ctrl),
    .ld_count(dec_count), .ld_addr(dec_addr), .wr_open(cpu_wr_open),
    .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .ctrl_q(ch0_ctrl), .count_q(ch0_count),
    .addr_q(ch0_addr)
  );

  always_comb begin
    ack_n_d = !(stg_valid && dec_ok);
    sel_d   = stg_valid && dec_ok && (dec_chan != 2'b00);
    err_d   = stg_valid && !dec_ok;
    id_en   = stg_valid && dec_ok;
    id_d    = dec_chan;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_n       <= 1'b1;
      chsel_pulse <= 1'b0;
      req_err     <= 1'b0;
      chan_id     <= 2'b00;
    end else begin
      ack_n       <= ack_n_d;
      chsel_pulse <= sel_d;
      req_err     <= err_d;
      if (id_en) chan_id <= id_d;
    end
  end
endmodule

// File: rtl/dtr_decoder_chk.sv
module dtr_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [63:0] req_word,
  input logic        cpu_wr_open,
  input logic        cpu_we,
  input logic [1:0]  cpu_sel,
  input logic        ack_n,
  input logic [1:0]  chan_id,
  input logic        chsel_pulse,
  input logic        req_err,
  input logic [15:0] ctrl_q,
  input logic [31:0] addr_q
);
  assert_ack_has_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> $past(req_valid, 2));

  assert_dst_side_from_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && chan_id == 2'b00) |-> (ctrl_q[4] == ($past(req_word[57:56], 2) == 2'b01)));

  assert_select_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chsel_pulse |-> (!ack_n && chan_id != 2'b00));

  assert_error_without_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (ack_n && !chsel_pulse));

  assert_addr_change_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_q) |-> ((!ack_n && chan_id == 2'b00) ||
                          $past(cpu_wr_open && cpu_we && cpu_sel == 2'd2)));
endmodule

bind dtr_decoder dtr_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
  .cpu_wr_open(cpu_wr_open), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
  .ack_n(ack_n), .chan_id(chan_id), .chsel_pulse(chsel_pulse),
  .req_err(req_err), .ctrl_q(ch0_ctrl), .addr_q(ch0_addr)
);

// File: tb/sim_dtr_decoder.sv
`timescale 1ns/1ps
module sim_dtr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_word = '0;
  logic        cpu_wr_open = 1'b0;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_sel = 2'd0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        ack_n;
  logic [1:0]  chan_id;
  logic        chsel_pulse;
  logic        req_err;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int         due;
    bit         ack;
    logic [1:0] id;
    bit         err;
    bit         sel;
  } exp_t;
  exp_t sb[$];

  logic [15:0] m_ctrl = '0;
  logic [7:0]  m_cnt = '0;
  logic [31:0] m_addr = '0;

  dtr_decoder u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
    .cpu_wr_open(cpu_wr_open), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ack_n(ack_n),
    .chan_id(chan_id), .chsel_pulse(chsel_pulse), .req_err(req_err)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(logic [2:0] sz, logic [1:0] id, logic dir,
                                     logic [1:0] md, logic [7:0] cnt,
                                     logic [15:0] gap, logic [31:0] ad);
    return {sz, id, dir, md, cnt, gap, ad};
  endfunction

  function automatic logic [15:0] want_ctrl(logic [2:0] sz, logic dir, logic [1:0] md);
    return {3'b000, 2'b01, 2'b01, (dir ? 4'b0011 : 4'b0010),
            (md == 2'b01), (md != 2'b11), sz};
  endfunction

  // driver: pushes expected strobes and updates the register model
  task automatic send(logic [63:0] w);
    exp_t e;
    bit ok;
    @(negedge clk);
    req_valid = 1'b1;
    req_word  = w;
    ok = (w[63:61] <= 3'd2) && (w[57:56] != 2'b00);
    e.due = cyc + 2;
    e.ack = ok;
    e.id  = w[60:59];
    e.err = !ok;
    e.sel = ok && (w[60:59] != 2'b00);
    sb.push_back(e);
    if (ok && w[60:59] == 2'b00) begin
      m_ctrl = want_ctrl(w[63:61], w[58], w[57:56]);
      m_cnt  = w[55:48];
      m_addr = w[31:0];
    end
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cpu_write(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_sel = s; cpu_wdata = d;
    if (cpu_wr_open) begin
      if (s == 2'd0) m_ctrl = d[15:0];
      else if (s == 2'd1) m_cnt = d[7:0];
      else if (s == 2'd2) m_addr = d;
    end
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic read_all(string req);
    @(negedge clk);
    cpu_sel = 2'd0; #0.5; chk({req, " ctrl"}, {32'd0, cpu_rdata}, {48'd0, m_ctrl});
    cpu_sel = 2'd1; #0.5; chk({req, " count"}, {32'd0, cpu_rdata}, {56'd0, m_cnt});
    cpu_sel = 2'd2; #0.5; chk({req, " addr"}, {32'd0, cpu_rdata}, {32'd0, m_addr});
    cpu_sel = 2'd3; #0.5; chk("R12 unused select", {32'd0, cpu_rdata}, 64'd0);
  endtask

  // monitor: compares strobes against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        chk("R1 ack", {63'd0, ack_n}, {63'd0, !e.ack});
        chk("R8 err", {63'd0, req_err}, {63'd0, e.err});
        chk("R7 select", {63'd0, chsel_pulse}, {63'd0, e.sel});
        if (e.ack) chk("R1 chan_id", {62'd0, chan_id}, {62'd0, e.id});
      end else if (ack_n !== 1'b1 || req_err !== 1'b0 || chsel_pulse !== 1'b0) begin
        checks++;
        fails++;
        $display("FAIL R1 idle strobes actual=%b%b%b expected=100",
                 ack_n, req_err, chsel_pulse);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 ack_n", {63'd0, ack_n}, 64'd1);
    chk("R11 err", {63'd0, req_err}, 64'd0);
    chk("R11 sel", {63'd0, chsel_pulse}, 64'd0);
    chk("R11 chan_id", {62'd0, chan_id}, 64'd0);
    read_all("R11");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5 R6: mode 01, 32-bit, write direction, gap bits set
    send(mk(3'b010, 2'b00, 1'b1, 2'b01, 8'h5A, 16'hFFFF, 32'hDEADBEEF));
    read_all("R2 R3 R4 R5 R6");
    // mode 10, 8-bit, read direction
    send(mk(3'b000, 2'b00, 1'b0, 2'b10, 8'h01, 16'h1234, 32'h00001000));
    read_all("R4 R5 mode10");
    // mode 11, 16-bit
    send(mk(3'b001, 2'b00, 1'b1, 2'b11, 8'hFF, 16'h0000, 32'h80000004));
    read_all("R4 mode11");

    // R7: channels 1..3 leave registers alone
    send(mk(3'b010, 2'b10, 1'b0, 2'b01, 8'h11, 16'h0, 32'h12345678));
    read_all("R7 ch2");
    send(mk(3'b000, 2'b01, 1'b1, 2'b10, 8'h22, 16'h0, 32'h0BADF00D));
    send(mk(3'b001, 2'b11, 1'b0, 2'b11, 8'h33, 16'h0, 32'hCAFE0000));
    read_all("R7 ch1 ch3");

    // R8: malformed requests
    send(mk(3'b010, 2'b00, 1'b0, 2'b00, 8'h44, 16'h0, 32'h44444444));
    read_all("R8 mode00");
    send(mk(3'b101, 2'b00, 1'b1, 2'b01, 8'h55, 16'h0, 32'h55555555));
    send(mk(3'b011, 2'b10, 1'b1, 2'b01, 8'h66, 16'h0, 32'h66666666));
    read_all("R8 size");
    // chan_id holds after errors
    chk("R8 chan_id kept", {62'd0, chan_id}, 64'd3);

    // R9: writes refused
    cpu_wr_open = 1'b0;
    cpu_write(2'd2, 32'hA5A5A5A5);
    cpu_write(2'd0, 32'h0000FFFF);
    cpu_write(2'd1, 32'h000000C3);
    read_all("R9");

    // R10: writes accepted, then overwritten
    cpu_wr_open = 1'b1;
    cpu_write(2'd2, 32'h13572468);
    cpu_write(2'd1, 32'h0000007E);
    cpu_write(2'd0, 32'h00008001);
    read_all("R10 write");
    send(mk(3'b000, 2'b00, 1'b0, 2'b11, 8'h09, 16'hABCD, 32'h00C0FFEE));
    read_all("R10 overwrite");

    repeat (4) @(negedge clk);
    chk("R1 scoreboard drained", {32'd0, 32'(sb.size())}, 64'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule